// File: doc/BRIEF.md
# APB Slave Select and Return Multiplexer

This block sits between an APB bridge controller and a set of APB slaves. It takes the transfer address that the controller has already captured and works out which slave owns it. Each slave has a base address and a count of low address bits that the slave decodes itself. For each slave the block drops that many low bits from both the address and the base, then compares what is left for equality. No adder or magnitude comparator appears in the select path. The select vector is registered and gated by an enable from the controller, so a select bit is high only while the controller is running the setup and access phases of a transfer.

In the return direction the block merges the read data, ready and error signals of all slaves into one set for the controller. Every merge is an AND-mask with the slave's select bit, followed by an OR over all slaves. When no select bit is set, the merged outputs are zero. A registered miss flag tells the controller that the address matched no slave, so it can answer with an error. Address ranges are expected not to overlap; remapping and overlap arbitration are not part of this block.

Top module: `apb_sel_route`

## Requirements
- R1: On each rising clock edge with `sel_en_i` high, bit i of `psel_o` becomes 1 if and only if `addr_i` lies in slave i's range. Slave i's range is every address whose bits above `SLV_LOW[i]` equal those of `SLV_BASE[i]`. With the default parameters the ranges are 0x1000–0x10FF (slave 0), 0x1100–0x11FF (slave 1), 0x2000–0x2FFF (slave 2) and 0x3000–0x3FFF (slave 3).
- R2: On a rising edge with `sel_en_i` low, `psel_o` becomes all zero, whatever the address.
- R3: On every rising edge `no_hit_o` is loaded with 1 when `addr_i` matches no slave and with 0 when it matches one. This happens whether `sel_en_i` is high or low.
- R4: `prdata_o` equals the `prdata_i` slice (bits i*DW up to i*DW+DW-1) of the slave whose `psel_o` bit is set. It is zero when no bit is set, and the data of slaves that are not selected has no effect.
- R5: `pready_o` equals `pready_i[i]` of the selected slave i and is 0 when no slave is selected.
- R6: `pslverr_o` equals `pslverr_i[i]` of the selected slave i and is 0 when no slave is selected.
- R7: With ranges that do not overlap, at most one bit of `psel_o` is high for any address.
- R8: While `rst_n` is low, `psel_o` and `no_hit_o` are 0, independent of the clock and the inputs.
- R9: Address bits below a slave's low-bit count never change whether that slave is selected. The first and last address of each range select it, and the addresses just outside a range do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Captured transfer address |
| sel_en_i | input | 1 | Allows select bits to be set (APB setup and access phases) |
| prdata_i | input | N_SLV*DW | Read data of all slaves; slave i in bits i*DW up to i*DW+DW-1 |
| pready_i | input | N_SLV | Ready of each slave |
| pslverr_i | input | N_SLV | Error response of each slave |
| psel_o | output | N_SLV | Registered one-hot slave select |
| no_hit_o | output | 1 | Registered flag: the address matched no slave |
| prdata_o | output | DW | Merged read data of the selected slave |
| pready_o | output | 1 | Merged ready of the selected slave |
| pslverr_o | output | 1 | Merged error of the selected slave |

## Verification
`psel_o` and `no_hit_o` are due one rising edge after `addr_i` and `sel_en_i` are applied. The merged return outputs follow `psel_o` and the slave inputs within that same cycle, with no register between them. The bench therefore drives each new address, enable and slave return pattern at a falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge against ranges and select patterns it computes itself. The reset check samples while reset is held across two rising edges, with an enabled, matching address on the inputs.

// File: rtl/apb_sel_pkg.sv
package apb_sel_pkg;

    // Width of each per-slave low-bit count field in the packed parameter.
    localparam int unsigned LOWCNT_W = 8;

    // True when a and b agree in every bit at or above position low.
    // Only XOR and a constant shift: no carry chain in the select path.
    function automatic logic upper_match(
        input logic [63:0] a,
        input logic [63:0] b,
        input int unsigned low
    );
        logic [63:0] diff;
        diff = (a ^ b) >> low;
        return (diff == 64'd0);
    endfunction

endpackage

// File: rtl/apb_addr_match.sv
module apb_addr_match #(
    parameter int unsigned N_SLV = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned LW    = apb_sel_pkg::LOWCNT_W,
    parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
    parameter logic [N_SLV*LW-1:0] SLV_LOW  = '0
) (
    input  logic [AW-1:0]    addr_i,
    output logic [N_SLV-1:0] hit_o
);

    // One equality comparator per slave on the bits above its own low count.
    for (genvar i = 0; i < N_SLV; i++) begin : g_slv
        localparam logic [AW-1:0] BASE_I = SLV_BASE[i*AW +: AW];
        localparam int unsigned   LOW_I  = int'(SLV_LOW[i*LW +: LW]);

        assign hit_o[i] = apb_sel_pkg::upper_match(64'(addr_i), 64'(BASE_I), LOW_I);
    end

endmodule

// File: rtl/apb_andor_mux.sv
module apb_andor_mux #(
    parameter int unsigned N_SLV = 4,
    parameter int unsigned W     = 32
) (
    input  logic [N_SLV-1:0]   sel_i,
    input  logic [N_SLV*W-1:0] din_i,
    output logic [W-1:0]       dout_o
);

    // Mask each lane with its select bit, then OR all lanes together.
    always_comb begin
        dout_o = '0;
        for (int i = 0; i < N_SLV; i++) begin
            dout_o = dout_o | (din_i[i*W +: W] & {W{sel_i[i]}});
        end
    end

endmodule

// File: rtl/apb_sel_route.sv
module apb_sel_route #(
    parameter int unsigned N_SLV = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    parameter logic [N_SLV*AW-1:0] SLV_BASE =
        {16'h3000, 16'h2000, 16'h1100, 16'h1000},
    parameter logic [N_SLV*apb_sel_pkg::LOWCNT_W-1:0] SLV_LOW =
        {8'd12, 8'd12, 8'd8, 8'd8}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr_i,
    input  logic                sel_en_i,
    input  logic [N_SLV*DW-1:0] prdata_i,
    input  logic [N_SLV-1:0]    pready_i,
    input  logic [N_SLV-1:0]    pslverr_i,
    output logic [N_SLV-1:0]    psel_o,
    output logic                no_hit_o,
    output logic [DW-1:0]       prdata_o,
    output logic                pready_o,
    output logic                pslverr_o
);

    localparam int unsigned LW = apb_sel_pkg::LOWCNT_W;

    typedef struct packed {
        logic [N_SLV-1:0] sel;
        logic             miss;
    } dec_st_t;

    logic [N_SLV-1:0] hit;
    dec_st_t          st_d;
    dec_st_t          st_q;

    apb_addr_match #(
        .N_SLV    (N_SLV),
        .AW       (AW),
        .LW       (LW),
        .SLV_BASE (SLV_BASE),
        .SLV_LOW  (SLV_LOW)
    ) u_match (
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sel  = sel_en_i ? hit : '0;
        st_d.miss = ~|hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psel_o   = st_q.sel;
    assign no_hit_o = st_q.miss;

    apb_andor_mux #(.N_SLV(N_SLV), .W(DW)) u_mux_data (
        .sel_i  (st_q.sel),
        .din_i  (prdata_i),
        .dout_o (prdata_o)
    );

    apb_andor_mux #(.N_SLV(N_SLV), .W(1)) u_mux_ready (
        .sel_i  (st_q.sel),
        .din_i  (pready_i),
        .dout_o (pready_o)
    );

    apb_andor_mux #(.N_SLV(N_SLV), .W(1)) u_mux_err (
        .sel_i  (st_q.sel),
        .din_i  (pslverr_i),
        .dout_o (pslverr_o)
    );

endmodule

// File: rtl/apb_sel_route_chk.sv
module apb_sel_route_chk #(
    parameter int unsigned N_SLV = 4,
    parameter int unsigned DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_en_i,
    input logic [N_SLV-1:0] psel_o,
    input logic             no_hit_o,
    input logic [DW-1:0]    prdata_o,
    input logic             pready_o,
    input logic             pslverr_o
);

    // R7
    psel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel_o));

    // R2
    psel_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en_i |=> (psel_o == '0));

    // R3
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_o != '0) |-> !no_hit_o);

    // R4
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_o == '0) |-> (prdata_o == '0));

    // R5
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_o == '0) |-> !pready_o);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_o == '0) |-> !pslverr_o);

endmodule

bind apb_sel_route apb_sel_route_chk #(
    .N_SLV (N_SLV),
    .DW    (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_en_i  (sel_en_i),
    .psel_o    (psel_o),
    .no_hit_o  (no_hit_o),
    .prdata_o  (prdata_o),
    .pready_o  (pready_o),
    .pslverr_o (pslverr_o)
);

// File: tb/sim_apb_sel_route.sv
`timescale 1ns/1ps
module sim_apb_sel_route;

    localparam int NS = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr_i = '0;
    logic             sel_en_i = 1'b0;
    logic [NS*DW-1:0] prdata_i = '0;
    logic [NS-1:0]    pready_i = '0;
    logic [NS-1:0]    pslverr_i = '0;
    logic [NS-1:0]    psel_o;
    logic             no_hit_o;
    logic [DW-1:0]    prdata_o;
    logic             pready_o;
    logic             pslverr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    apb_sel_route u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .sel_en_i  (sel_en_i),
        .prdata_i  (prdata_i),
        .pready_i  (pready_i),
        .pslverr_i (pslverr_i),
        .psel_o    (psel_o),
        .no_hit_o  (no_hit_o),
        .prdata_o  (prdata_o),
        .pready_o  (pready_o),
        .pslverr_o (pslverr_o)
    );

    // Owning slave computed from plain range limits; -1 when none.
    function automatic int owner(input logic [AW-1:0] a);
        int v = int'(a);
        if (v >= 'h1000 && v < 'h1100) return 0;
        if (v >= 'h1100 && v < 'h1200) return 1;
        if (v >= 'h2000 && v < 'h3000) return 2;
        if (v >= 'h3000 && v < 'h4000) return 3;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one address with enable and return pattern, then check all outputs.
    task automatic step(input logic [AW-1:0] a, input bit en);
        int            s;
        logic [NS-1:0] exp_sel;
        logic [DW-1:0] exp_rd;
        bit            exp_rdy;
        bit            exp_err;
        @(negedge clk);
        addr_i   = a;
        sel_en_i = en;
        for (int i = 0; i < NS; i++) begin
            prdata_i[i*DW +: DW] = {8'(i + 1), a[7:0], 16'hB5E0 ^ 16'(a)};
        end
        pready_i  = a[4] ? 4'b1010 : 4'b0101;
        pslverr_i = a[5] ? 4'b0011 : 4'b1100;
        @(negedge clk);
        s       = owner(a);
        exp_sel = (en && s >= 0) ? NS'(1 << s) : '0;
        exp_rd  = '0;
        exp_rdy = 1'b0;
        exp_err = 1'b0;
        if (exp_sel != '0) begin
            exp_rd  = {8'(s + 1), a[7:0], 16'hB5E0 ^ 16'(a)};
            exp_rdy = pready_i[s];
            exp_err = pslverr_i[s];
        end
        // R1 R2 R9
        chk(psel_o == exp_sel, en ? "R1/R9 psel" : "R2 psel", 64'(psel_o), 64'(exp_sel));
        // R7
        chk($countones(psel_o) <= 1, "R7 at most one psel", 64'(psel_o), 64'(exp_sel));
        // R3
        chk(no_hit_o == (s < 0), "R3 no_hit", 64'(no_hit_o), 64'(s < 0));
        // R4
        chk(prdata_o == exp_rd, "R4 prdata", 64'(prdata_o), 64'(exp_rd));
        // R5
        chk(pready_o == exp_rdy, "R5 pready", 64'(pready_o), 64'(exp_rdy));
        // R6
        chk(pslverr_o == exp_err, "R6 pslverr", 64'(pslverr_o), 64'(exp_err));
    endtask

    initial begin
        logic [AW-1:0] edges [13] = '{16'h0FFF, 16'h1000, 16'h10FF, 16'h1100,
                                      16'h11FF, 16'h1200, 16'h1FFF, 16'h2000,
                                      16'h2FFF, 16'h3000, 16'h3FFF, 16'h4000,
                                      16'hFFFF};
        // R8: reset held with a matching, enabled address on the inputs
        addr_i   = 16'h1000;
        sel_en_i = 1'b1;
        pready_i = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(psel_o == '0, "R8 psel in reset", 64'(psel_o), 64'h0);
        chk(no_hit_o == 1'b0, "R8 no_hit in reset", 64'(no_hit_o), 64'h0);
        chk(pready_o == 1'b0, "R8 pready in reset", 64'(pready_o), 64'h0);
        rst_n = 1'b1;

        // R9: range edges, enabled then disabled
        foreach (edges[k]) step(edges[k], 1'b1);
        foreach (edges[k]) step(edges[k], 1'b0);

        // R1 R2 R3: sweep of the whole address space, enable mixed in
        for (int a = 0; a < 65536; a += 16) begin
            step(AW'(a), (a[7:6] != 2'b11));
        end
        // low offsets inside one range with varying low bits
        for (int a = 'h2000; a < 'h2010; a++) begin
            step(AW'(a), 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule